// File: doc/BRIEF.md
# Bit-Field Read-Modify-Write Engine

The engine updates one bit field of a word in a register array and leaves every other bit of that word as it was. A host hands it a single 32-bit descriptor, which carries the word address, the field width and the bit offset, together with a value. The engine then reads the addressed word and clears the bits of the field. It places the value, cut down to the field width, into those bits and writes the word back.

The host side is a valid/busy/done handshake. The host raises `req_valid` with the descriptor and value. The engine takes the request on the next clock edge if it is idle. It keeps `busy` high while it reads and writes, and it pulses `done` for one cycle once the write has happened.

The memory side is a plain synchronous port. A read strobe returns data on the following cycle, and a write strobe stores `mem_wdata` at the clock edge. The engine adds a fixed base, set by a parameter, to the descriptor's address field to form the word address.

Top module: `field_rmw_engine`

## Requirements
- R1: The descriptor is decoded as word address in bits [31:16], field width in bits [15:8] and bit offset in bits [7:0].
- R2: The memory address used for both the read and the write equals BASE_ADDR plus the descriptor address field, taken modulo 2^ADDR_W.
- R3: In the written word, every bit outside the field (bit index below the offset, or at or above offset plus width) equals the bit that was read.
- R4: Field bit i (offset <= i < offset+width) is written with value bit i-offset, so value bits at or above the width never reach the word.
- R5: Width 32 with offset 0 writes the whole value as the word.
- R6: A field running past bit 31 is clipped there. Width 0 or an offset of 32 or more writes the word back unchanged.
- R7: The read strobe is high in the first cycle after acceptance. The write strobe is high in the next cycle, at the same address, and the two strobes are never high together.
- R8: `busy` is high from the cycle after acceptance through the write cycle. `done` is high for exactly the one cycle after the write, with `busy` low in that cycle.
- R9: A request presented while `busy` is high is ignored. A request held until `busy` falls is accepted in the `done` cycle.
- R10: After reset, `busy`, `done`, `mem_re` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| req_valid | input | 1 | Request present |
| req_desc | input | 32 | Packed field descriptor |
| req_value | input | DATA_W | Value to insert into the field |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Read strobe, data returned next cycle |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Word address for read and write |
| mem_wdata | output | DATA_W | Merged word to write |
| mem_rdata | input | DATA_W | Read data, valid the cycle after mem_re |

## Verification
Two things can fall in the same cycle: the completion pulse of one operation and the acceptance of the next request. The bench raises a second request in the read cycle and holds it through the write and `done` cycles. It checks that the write still goes to the first address with the first merged word. It also checks that the held request is taken only at the edge that ends the `done` cycle, with a new read to the second address in the following cycle. In a second variant the bench drops the held request before `done`. It then checks that no new read starts and that the second target word is unchanged.

// File: rtl/field_rmw_pkg.sv
package field_rmw_pkg;

  localparam int DESC_W   = 32;
  localparam int FIELD_IW = 8;
  localparam int WADDR_IW = 16;

  typedef struct packed {
    logic [WADDR_IW-1:0] word;
    logic [FIELD_IW-1:0] width;
    logic [FIELD_IW-1:0] offset;
  } fdesc_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } rmw_state_e;

endpackage

// File: rtl/rmw_ctrl.sv
module rmw_ctrl
  import field_rmw_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [DESC_W-1:0]   req_desc,
  input  logic [DATA_W-1:0]   req_value,
  output logic                busy,
  output logic                done,
  output logic                rd_en,
  output logic                wr_en,
  output logic [ADDR_W-1:0]   tgt_addr,
  output logic [FIELD_IW-1:0] fld_width,
  output logic [FIELD_IW-1:0] fld_offset,
  output logic [DATA_W-1:0]   fld_value
);

  rmw_state_e state_q, state_d;
  logic       done_q, done_d;
  logic       accept;
  fdesc_t     desc_in, desc_q;
  logic [ADDR_W-1:0] tgt_d, tgt_q;
  logic [DATA_W-1:0] value_q;

  assign desc_in = fdesc_t'(req_desc);
  assign tgt_d   = ADDR_W'(32'(BASE_ADDR) + {16'b0, desc_in.word});

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          accept  = 1'b1;
          state_d = ST_READ;
        end
      end
      ST_READ:  state_d = ST_WRITE;
      ST_WRITE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    done_d = (state_q == ST_WRITE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_q  <= '0;
      tgt_q   <= '0;
      value_q <= '0;
    end else if (accept) begin
      desc_q  <= desc_in;
      tgt_q   <= tgt_d;
      value_q <= req_value;
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = done_q;
  assign rd_en      = (state_q == ST_READ);
  assign wr_en      = (state_q == ST_WRITE);
  assign tgt_addr   = tgt_q;
  assign fld_width  = desc_q.width;
  assign fld_offset = desc_q.offset;
  assign fld_value  = value_q;

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (done && !busy));
  a_r7_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (wr_en && $stable(tgt_addr)));
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
  a_r9_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(fld_width) && $stable(fld_offset) && $stable(fld_value)));

endmodule

// File: rtl/rmw_field_mask.sv
module rmw_field_mask
  import field_rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [FIELD_IW-1:0] fld_width,
  input  logic [FIELD_IW-1:0] fld_offset,
  output logic [DATA_W-1:0]   fld_mask
);

  localparam int SUM_W = FIELD_IW + 2;

  logic [SUM_W-1:0] lo, hi;

  assign lo = SUM_W'(fld_offset);
  assign hi = SUM_W'(fld_offset) + SUM_W'(fld_width);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [SUM_W-1:0] IDX = SUM_W'(i);
    assign fld_mask[i] = (IDX >= lo) && (IDX < hi);
  end

endmodule

// File: rtl/rmw_merge.sv
module rmw_merge
  import field_rmw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]   old_word,
  input  logic [DATA_W-1:0]   fld_value,
  input  logic [FIELD_IW-1:0] fld_offset,
  input  logic [DATA_W-1:0]   fld_mask,
  output logic [DATA_W-1:0]   new_word
);

  logic [DATA_W-1:0] placed;

  assign placed   = fld_value << fld_offset;
  assign new_word = (old_word & ~fld_mask) | (placed & fld_mask);

endmodule

// File: rtl/field_rmw_engine.sv
module field_rmw_engine
  import field_rmw_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_desc,
  input  logic [DATA_W-1:0] req_value,
  output logic              busy,
  output logic              done,
  output logic              mem_re,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);

  logic [FIELD_IW-1:0] fld_width, fld_offset;
  logic [DATA_W-1:0]   fld_value, fld_mask;

  rmw_ctrl #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_desc   (req_desc),
    .req_value  (req_value),
    .busy       (busy),
    .done       (done),
    .rd_en      (mem_re),
    .wr_en      (mem_we),
    .tgt_addr   (mem_addr),
    .fld_width  (fld_width),
    .fld_offset (fld_offset),
    .fld_value  (fld_value)
  );

  rmw_field_mask #(.DATA_W(DATA_W)) i_mask (
    .fld_width  (fld_width),
    .fld_offset (fld_offset),
    .fld_mask   (fld_mask)
  );

  rmw_merge #(.DATA_W(DATA_W)) i_merge (
    .old_word   (mem_rdata),
    .fld_value  (fld_value),
    .fld_offset (fld_offset),
    .fld_mask   (fld_mask),
    .new_word   (mem_wdata)
  );

  a_r5_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && fld_offset == '0 && 32'(fld_width) >= DATA_W) |-> (mem_wdata == fld_value));
  a_r6_empty_field: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (fld_width == '0 || 32'(fld_offset) >= DATA_W)) |-> (mem_wdata == mem_rdata));
  a_r3_below_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && fld_offset != '0 && 32'(fld_offset) < DATA_W) |->
      (((mem_wdata ^ mem_rdata) & ((DATA_W'(1) << fld_offset) - DATA_W'(1))) == '0));

endmodule

// File: tb/test_field_rmw_engine.sv
module test_field_rmw_engine;

  localparam int DW    = 32;
  localparam int AW    = 4;
  localparam int BASE  = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_desc = '0;
  logic [DW-1:0] req_value = '0;
  logic          busy, done, mem_re, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem_q [DEPTH];
  logic          pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [DW-1:0] pre_data = '0;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  field_rmw_engine #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) i_field_rmw_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_desc(req_desc),
    .req_value(req_value), .busy(busy), .done(done), .mem_re(mem_re),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (pre_we) mem_q[pre_addr] <= pre_data;
    else if (mem_we) mem_q[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem_q[mem_addr];
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expect_word(input logic [DW-1:0] old,
      input logic [DW-1:0] v, input int w, input int o);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++)
      r[i] = (i >= o && i < o + w) ? v[i-o] : old[i];
    return r;
  endfunction

  function automatic logic [AW-1:0] target_of(input logic [31:0] d);
    return AW'((BASE + int'(d[31:16])) % DEPTH);
  endfunction

  task automatic preload(input logic [AW-1:0] a, input logic [DW-1:0] v);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = a; pre_data = v;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  task automatic run_op(input logic [31:0] d, input logic [DW-1:0] v, input logic [DW-1:0] old);
    logic [AW-1:0] t;
    logic [DW-1:0] e;
    int w, o;
    string tag;
    w = int'(d[15:8]);
    o = int'(d[7:0]);
    t = target_of(d);
    e = expect_word(old, v, w, o);
    if (w >= 32 && o == 0) tag = "R5";
    else if (w == 0 || o >= 32 || o + w > 32) tag = "R6";
    else tag = "R3 R4";
    preload(t, old);
    @(negedge clk);
    req_valid = 1'b1; req_desc = d; req_value = v;
    @(negedge clk);
    req_valid = 1'b0;
    check("R7 read strobe", {63'b0, mem_re & ~mem_we}, 64'd1);
    check("R1 R2 read address", {60'b0, mem_addr}, {60'b0, t});
    check("R8 busy in read", {63'b0, busy}, 64'd1);
    @(negedge clk);
    check("R7 write strobe", {63'b0, mem_we & ~mem_re}, 64'd1);
    check("R2 write address", {60'b0, mem_addr}, {60'b0, t});
    check(tag, {32'b0, mem_wdata}, {32'b0, e});
    @(negedge clk);
    check("R8 done pulse", {62'b0, done, busy}, 64'd2);
    check(tag, {32'b0, mem_q[t]}, {32'b0, e});
    @(negedge clk);
    check("R8 done single", {63'b0, done}, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d1, d2;
    logic [AW-1:0] ta, tb;
    #1;
    check("R10 reset outputs", {60'b0, busy, done, mem_re, mem_we}, 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 after release", {60'b0, busy, done, mem_re, mem_we}, 64'd0);

    for (int w = 0; w <= 34; w++)
      for (int o = 0; o <= 34; o++)
        run_op({16'($urandom), 8'(w), 8'(o)}, $urandom, $urandom);
    run_op({16'hFFFF, 8'd255, 8'd0}, 32'hDEADBEEF, 32'h0);
    run_op({16'h0010, 8'd32, 8'd0}, 32'h12345678, 32'hFFFFFFFF);
    run_op({16'h0003, 8'd255, 8'd255}, 32'hFFFFFFFF, 32'hA5A5A5A5);

    // R9: request during busy, dropped before done -> ignored
    d1 = {16'd1, 8'd8, 8'd4};
    d2 = {16'd5, 8'd32, 8'd0};
    ta = target_of(d1); tb = target_of(d2);
    preload(ta, 32'h11111111);
    preload(tb, 32'h22222222);
    @(negedge clk);
    req_valid = 1'b1; req_desc = d1; req_value = 32'hAB;
    @(negedge clk);
    req_desc = d2; req_value = 32'hFFFFFFFF;
    @(negedge clk);
    check("R9 write keeps first address", {60'b0, mem_addr}, {60'b0, ta});
    check("R9 write keeps first value", {32'b0, mem_wdata}, {32'b0, 32'h11111AB1});
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 done cycle", {62'b0, done, busy}, 64'd2);
    @(negedge clk);
    check("R9 ignored no read", {62'b0, busy, mem_re}, 64'd0);
    check("R9 ignored word untouched", {32'b0, mem_q[tb]}, {32'b0, 32'h22222222});

    // R9: request held through done -> accepted back to back
    preload(ta, 32'h0);
    @(negedge clk);
    req_valid = 1'b1; req_desc = d1; req_value = 32'h5;
    @(negedge clk);
    req_desc = d2; req_value = 32'hCAFEF00D;
    @(negedge clk);
    check("R9 first write", {32'b0, mem_wdata}, {32'b0, 32'h00000050});
    @(negedge clk);
    check("R9 done with held request", {62'b0, done, busy}, 64'd2);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 held request read", {59'b0, busy, mem_re, mem_addr}, {59'b0, 2'b11, tb});
    @(negedge clk);
    check("R9 held request write", {32'b0, mem_wdata}, {32'b0, 32'hCAFEF00D});
    repeat (2) @(negedge clk);
    check("R9 held request stored", {32'b0, mem_q[tb]}, {32'b0, 32'hCAFEF00D});

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule